// File: doc/BRIEF.md
# Bayer black level compensation unit

This block removes the dark offset from a stream of 10-bit Bayer pixel samples. Each sample arrives with a valid strobe, the parity of its row and column, and a flag that marks samples taken from the light-shielded rows. The shielded rows are two lines above and two lines below the active array, four lines per frame. For each colour channel, the block adds up the shielded samples that pass a programmable threshold, together with a count of them. At the next frame start it turns each channel's mean into a signed offset: the initial offset minus the mean.

Active pixels then receive the offset of their own channel. The result is clamped to the 10-bit range and leaves on a registered output one cycle later. Shielded samples go through unchanged. When compensation is disabled, all samples go through unchanged. The host pulses `frame_start` once per frame. The correction is therefore constant across the active pixels of one frame and follows the black level from frame to frame.

Top module: `blc_unit`

## Requirements
- R1: Channel decode: a sample on an even row (`pix_row_odd`=0) is green at an even column and blue at an odd column. A sample on an odd row is red at an even column and green at an odd column.
- R2: Only a sample with `pix_valid`=1, `pix_shield`=1 and a value less than or equal to `cfg_thresh` (zero-extended) adds to its channel's sum and count. A shielded sample strictly above the threshold is left out of the average.
- R3: On a clock edge with `frame_start`=1, each channel whose count is non-zero loads offset = initial offset − floor(sum / count). Sum and count are the totals gathered since the previous frame start.
- R4: A channel that gathered no qualifying sample keeps its previous offset at frame start.
- R5: Offsets change only on a `frame_start` edge. Changes to the initial offset inputs between frame starts have no effect until the next one. A qualifying sample accepted in the same cycle as `frame_start` counts toward the new frame's totals.
- R6: `out_valid` equals `pix_valid` delayed by exactly one clock.
- R7: With `cfg_enable`=1, an active (non-shielded) sample leaves as data + offset of its channel, saturated to 0 and 1023. It uses the offsets held before any frame start in the same cycle.
- R8: With `cfg_enable`=0, or for a shielded sample, `out_data` equals the input sample.
- R9: After reset, `out_valid` is 0 and all offsets are 0, so active pixels pass unchanged until the first frame start that has measured data.
- R10: A channel count stops at its maximum (4095 with default parameters). Further samples of that channel in the same frame change neither its sum nor its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame; latches offsets and clears totals |
| pix_valid | input | 1 | Sample strobe |
| pix_data | input | DATA_W | Pixel sample |
| pix_row_odd | input | 1 | Row parity of the sample |
| pix_col_odd | input | 1 | Column parity of the sample |
| pix_shield | input | 1 | Sample comes from a light-shielded row |
| cfg_enable | input | 1 | Apply compensation to active pixels |
| cfg_thresh | input | THR_W | Largest shielded value accepted into the average |
| cfg_init_r | input | INIT_W | Initial offset, red |
| cfg_init_g | input | INIT_W | Initial offset, green |
| cfg_init_b | input | INIT_W | Initial offset, blue |
| out_valid | output | 1 | Output strobe |
| out_data | output | DATA_W | Compensated sample |

## Verification
The compensated sample is due one clock after it is accepted, so the reference model computes its expected value at the capturing edge. It compares that value half a period later, on every cycle. A new offset takes effect for pixels accepted in the cycle after the `frame_start` edge. The model therefore updates its offsets after it has computed the output for the sample in that same edge, which is the ordering R5 and R7 require. The directed checks drive a sample one cycle, then read the output just after the next edge. This covers channel mapping, threshold exclusion, empty channels, both clamps, bypass and count saturation with hand-computed values.

// File: rtl/blc_pkg.sv
package blc_pkg;

  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } bayer_ch_e;

  // Mosaic: even rows carry green/blue, odd rows carry red/green.
  function automatic bayer_ch_e site_channel(input logic row_odd, input logic col_odd);
    if (!row_odd) return col_odd ? CH_BLU : CH_GRN;
    return col_odd ? CH_GRN : CH_RED;
  endfunction

endpackage

// File: rtl/blc_site_qual.sv
module blc_site_qual
  import blc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int THR_W  = 8
) (
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              row_odd,
  input  logic              col_odd,
  input  logic              shield,
  input  logic [THR_W-1:0]  thresh,
  output bayer_ch_e         site_ch,
  output logic              take
);

  logic under_limit;

  always_comb begin
    site_ch     = site_channel(row_odd, col_odd);
    under_limit = (pix_data <= DATA_W'(thresh));
    take        = pix_valid & shield & under_limit;
  end

endmodule

// File: rtl/blc_acc.sv
module blc_acc #(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     add,
  input  logic [DATA_W-1:0]        sample,
  output logic [DATA_W+CNT_W-1:0]  sum,
  output logic [CNT_W-1:0]         cnt
);

  localparam int SUM_W = DATA_W + CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      cnt <= '0;
    end else if (clear) begin
      sum <= add ? SUM_W'(sample) : '0;
      cnt <= add ? CNT_W'(1) : '0;
    end else if (add && !at_max) begin
      sum <= sum + SUM_W'(sample);
      cnt <= cnt + CNT_W'(1);
    end
  end

  p_count_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && at_max) |=> (cnt == CNT_MAX && $stable(sum)));

  p_idle_no_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !add) |=> ($stable(cnt) && $stable(sum)));

  p_clear_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt <= CNT_W'(1)));

endmodule

// File: rtl/blc_offset.sv
module blc_offset #(
  parameter int DATA_W = 10,
  parameter int INIT_W = 8,
  parameter int CNT_W  = 12,
  parameter int OFF_W  = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     latch,
  input  logic [DATA_W+CNT_W-1:0]  sum,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [INIT_W-1:0]        init,
  output logic signed [OFF_W-1:0]  off
);

  localparam int SUM_W = DATA_W + CNT_W;

  function automatic logic [DATA_W-1:0] mean_of(input logic [SUM_W-1:0] s,
                                               input logic [CNT_W-1:0] n);
    return DATA_W'(s / SUM_W'(n));
  endfunction

  function automatic logic signed [OFF_W-1:0] offset_of(input logic [INIT_W-1:0] base,
                                                       input logic [DATA_W-1:0] m);
    return $signed(OFF_W'(base)) - $signed(OFF_W'(m));
  endfunction

  logic has_data;
  logic signed [OFF_W-1:0] off_next;

  always_comb begin
    has_data = (cnt != '0);
    off_next = has_data ? offset_of(init, mean_of(sum, cnt)) : off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     off <= '0;
    else if (latch) off <= off_next;
  end

  p_hold_between_frames_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(off));

  p_empty_channel_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && cnt == '0) |=> $stable(off));

  p_zero_mean_gives_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && cnt != '0 && sum == '0) |=> (off == $signed(OFF_W'($past(init)))));

endmodule

// File: rtl/blc_apply.sv
module blc_apply #(
  parameter int DATA_W = 10,
  parameter int OFF_W  = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     correct,
  input  logic signed [OFF_W-1:0]  off,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data
);

  localparam int EXT_W = OFF_W + 2;
  localparam logic signed [EXT_W-1:0] TOP_VAL = EXT_W'((1 << DATA_W) - 1);

  function automatic logic [DATA_W-1:0] add_clamp(input logic [DATA_W-1:0] d,
                                                 input logic signed [OFF_W-1:0] o);
    logic signed [EXT_W-1:0] s;
    s = $signed(EXT_W'(d)) + EXT_W'(o);
    if (s < 0)       return '0;
    if (s > TOP_VAL) return '1;
    return s[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] fixed_data;
  assign fixed_data = correct ? add_clamp(in_data, off) : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= fixed_data;
    end
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !correct) |=> (out_data == $past(in_data)));

  p_no_offset_identity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && off == '0) |=> (out_data == $past(in_data)));

endmodule

// File: rtl/blc_unit.sv
module blc_unit
  import blc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int THR_W  = 8,
  parameter int INIT_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_row_odd,
  input  logic              pix_col_odd,
  input  logic              pix_shield,
  input  logic              cfg_enable,
  input  logic [THR_W-1:0]  cfg_thresh,
  input  logic [INIT_W-1:0] cfg_init_r,
  input  logic [INIT_W-1:0] cfg_init_g,
  input  logic [INIT_W-1:0] cfg_init_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int SUM_W = DATA_W + CNT_W;
  localparam int OFF_W = ((INIT_W > DATA_W) ? INIT_W : DATA_W) + 1;

  bayer_ch_e site_ch;
  logic      take;

  logic [INIT_W-1:0]       init_arr [NUM_CH];
  logic [SUM_W-1:0]        sum_arr  [NUM_CH];
  logic [CNT_W-1:0]        cnt_arr  [NUM_CH];
  logic signed [OFF_W-1:0] off_arr  [NUM_CH];
  logic signed [OFF_W-1:0] off_sel;
  logic                    do_fix;

  assign init_arr[0] = cfg_init_r;
  assign init_arr[1] = cfg_init_g;
  assign init_arr[2] = cfg_init_b;

  blc_site_qual #(.DATA_W(DATA_W), .THR_W(THR_W)) u_qual (
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .row_odd   (pix_row_odd),
    .col_odd   (pix_col_odd),
    .shield    (pix_shield),
    .thresh    (cfg_thresh),
    .site_ch   (site_ch),
    .take      (take)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic add_here;
    assign add_here = take && (site_ch == bayer_ch_e'(c));

    blc_acc #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (frame_start),
      .add    (add_here),
      .sample (pix_data),
      .sum    (sum_arr[c]),
      .cnt    (cnt_arr[c])
    );

    blc_offset #(.DATA_W(DATA_W), .INIT_W(INIT_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_off (
      .clk   (clk),
      .rst_n (rst_n),
      .latch (frame_start),
      .sum   (sum_arr[c]),
      .cnt   (cnt_arr[c]),
      .init  (init_arr[c]),
      .off   (off_arr[c])
    );
  end

  always_comb begin
    case (site_ch)
      CH_RED:  off_sel = off_arr[0];
      CH_BLU:  off_sel = off_arr[2];
      default: off_sel = off_arr[1];
    endcase
    do_fix = cfg_enable & ~pix_shield;
  end

  blc_apply #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_apply (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid),
    .in_data   (pix_data),
    .correct   (do_fix),
    .off       (off_sel),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  p_shield_not_corrected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_shield) |=> (out_data == $past(pix_data)));

endmodule

// File: tb/blc_unit_bench.sv
module blc_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_LIMIT  = 4095;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       pix_valid = 1'b0;
  logic [9:0] pix_data = '0;
  logic       pix_row_odd = 1'b0;
  logic       pix_col_odd = 1'b0;
  logic       pix_shield = 1'b0;
  logic       cfg_enable = 1'b1;
  logic [7:0] cfg_thresh = 8'hFF;
  logic [7:0] cfg_init_r = 8'h7F;
  logic [7:0] cfg_init_g = 8'h7F;
  logic [7:0] cfg_init_b = 8'h7F;
  logic       out_valid;
  logic [9:0] out_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  blc_unit u_blc_unit (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_row_odd(pix_row_odd), .pix_col_odd(pix_col_odd), .pix_shield(pix_shield),
    .cfg_enable(cfg_enable), .cfg_thresh(cfg_thresh),
    .cfg_init_r(cfg_init_r), .cfg_init_g(cfg_init_g), .cfg_init_b(cfg_init_b),
    .out_valid(out_valid), .out_data(out_data)
  );

  // ---------------- behavioural reference ----------------
  int m_sum [3];
  int m_cnt [3];
  int m_off [3];
  bit exp_v = 1'b0;
  int exp_d = 0;
  int m_ch;
  int m_v;

  function automatic int chan(input logic r, input logic c);
    if (!r) return c ? 2 : 1;
    return c ? 1 : 0;
  endfunction

  function automatic int init_of(input int c);
    if (c == 0) return int'(cfg_init_r);
    if (c == 1) return int'(cfg_init_g);
    return int'(cfg_init_b);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v = 1'b0;
      for (int c = 0; c < 3; c++) begin m_sum[c] = 0; m_cnt[c] = 0; m_off[c] = 0; end
    end else begin
      exp_v = pix_valid;
      m_ch  = chan(pix_row_odd, pix_col_odd);
      if (pix_valid) begin
        if (cfg_enable && !pix_shield) begin
          m_v = int'(pix_data) + m_off[m_ch];
          if (m_v < 0) m_v = 0;
          if (m_v > 1023) m_v = 1023;
          exp_d = m_v;
        end else exp_d = int'(pix_data);
      end
      if (frame_start) begin
        for (int c = 0; c < 3; c++) begin
          if (m_cnt[c] > 0) m_off[c] = init_of(c) - m_sum[c] / m_cnt[c];
          m_sum[c] = 0;
          m_cnt[c] = 0;
        end
      end
      if (pix_valid && pix_shield && int'(pix_data) <= int'(cfg_thresh) && m_cnt[m_ch] < CNT_LIMIT) begin
        m_sum[m_ch] += int'(pix_data);
        m_cnt[m_ch] += 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_valid !== exp_v || (exp_v && int'(out_data) != exp_d)) begin
        failures++;
        $display("FAIL %s model: valid=%0b data=%0d expected valid=%0b data=%0d",
                 tag, out_valid, out_data, exp_v, exp_d);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R6 watchdog: cycles=%0d expected < %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic push(input bit sh, input bit r, input bit c, input int d, input bit sof);
    pix_valid = 1'b1; pix_shield = sh; pix_row_odd = r; pix_col_odd = c;
    pix_data = 10'(d); frame_start = sof;
    @(posedge clk); #2;
    pix_valid = 1'b0; pix_shield = 1'b0; frame_start = 1'b0;
  endtask

  task automatic pulse_sof();
    frame_start = 1'b1;
    @(posedge clk); #2;
    frame_start = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle();
    // R9: reset state, offsets start at zero
    tag = "R9";
    chk("R9 out_valid after reset", int'(out_valid), 0);
    push(0, 0, 0, 321, 0);
    chk("R9 zero offset before measurement", int'(out_data), 321);

    // Frame 1 shielded data: G 20,30 -> 25 ; B 40 ; R 10 (300 excluded)
    tag = "R2";
    push(1, 0, 0, 20, 0);
    push(1, 0, 1, 40, 0);
    push(1, 0, 0, 30, 0);
    push(1, 1, 0, 10, 0);
    push(1, 1, 0, 300, 0);
    chk("R8 shielded sample passes", int'(out_data), 300);
    tag = "R3";
    pulse_sof();
    push(0, 0, 0, 100, 0);
    chk("R1 R3 green even row", int'(out_data), 202);
    push(0, 0, 1, 100, 0);
    chk("R1 R3 blue", int'(out_data), 187);
    push(0, 1, 0, 100, 0);
    chk("R1 R2 red excludes above threshold", int'(out_data), 217);
    push(0, 1, 1, 50, 0);
    chk("R1 green odd row", int'(out_data), 152);
    tag = "R7";
    push(0, 1, 0, 1000, 0);
    chk("R7 high clamp", int'(out_data), 1023);
    idle();
    chk("R6 out_valid drops", int'(out_valid), 0);

    // Frame 2: threshold boundary, red/blue empty
    tag = "R4";
    cfg_thresh = 8'd30;
    push(1, 0, 0, 30, 0);
    push(1, 0, 0, 31, 0);
    pulse_sof();
    push(0, 0, 0, 0, 0);
    chk("R2 threshold inclusive", int'(out_data), 97);
    push(0, 1, 0, 100, 0);
    chk("R4 red keeps offset", int'(out_data), 217);
    push(0, 0, 1, 100, 0);
    chk("R4 blue keeps offset", int'(out_data), 187);

    // Frame 3: init change mid-frame has no effect; sample with sof is new frame
    tag = "R5";
    cfg_thresh = 8'hFF;
    push(1, 0, 0, 200, 0);
    cfg_init_g = 8'd0;
    push(0, 0, 0, 100, 0);
    chk("R5 init change deferred", int'(out_data), 197);
    push(1, 0, 0, 50, 1);
    chk("R8 shielded with sof passes", int'(out_data), 50);
    push(0, 0, 0, 100, 0);
    chk("R7 low clamp", int'(out_data), 0);
    cfg_enable = 1'b0;
    push(0, 0, 0, 100, 0);
    chk("R8 disabled bypass", int'(out_data), 100);
    cfg_enable = 1'b1;
    pulse_sof();
    push(0, 0, 0, 100, 0);
    chk("R5 sof sample counted in new frame", int'(out_data), 50);

    // Saturation: 4095 green samples of 10, then 20 samples of 250
    tag = "R10";
    cfg_init_g = 8'd127;
    for (int i = 0; i < CNT_LIMIT; i++) push(1, 1, 1, 10, 0);
    for (int i = 0; i < 20; i++) push(1, 0, 0, 250, 0);
    pulse_sof();
    push(0, 0, 0, 100, 0);
    chk("R10 count saturates", int'(out_data), 217);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule